// File: doc/BRIEF.md
# Dual-Channel Serial-to-Parallel LCD Bias Selector

This block turns serial display data into forty parallel drive selections for an LCD panel. It has two independent channels of twenty outputs each. Each channel has a shift register that can be loaded from either end, a holding latch, and a per-output decoder. The decoder reports which of six bias rails the analog output stage should connect to. Serial bits enter on one strobe pin and are copied to the latch on a second strobe pin. The far end of each register is driven back out on the idle data pin, so several devices can be chained.

A mode pin lets channel 2 act as a row (common) driver while channel 1 stays a column (segment) driver. When mode is high, channel 2 swaps the roles of the two strobes and acts on their rising edges instead of their falling edges. Its rail mapping also swaps within each pair. The strobe and data pins are sampled through two-stage synchronizers on the system clock. A strobe edge therefore acts on the third rising `clk` edge after the pin changes. Strobe pins idle high.

Top module: `lcd_dual_drv`

## Requirements
- R1: An asynchronous active-low reset clears both shift registers and both latches to zero. Afterwards, with alt high, every channel 1 output reads code 3, every channel 2 output reads code 5, and the active data-out pins read 0.
- R2: With dir1 high, channel 1 takes its serial input from c1_right on each falling edge of ck_shf. The new bit enters register position 19 and the register moves toward position 0. c1_left presents position 0.
- R3: With a direction input low, the channel takes its serial input from its left pin. The new bit enters position 0 and the register moves toward position 19. The right pin presents position 19.
- R4: Channel 1 copies its register into its latch on each falling edge of ck_lat, in either mode. Shifting alone never changes the rail codes.
- R5: The code for channel 1 output k (rail bits 3k+2..3k) is 1 for latched 1 with alt high, 2 for latched 1 with alt low, 3 for latched 0 with alt high, and 4 for latched 0 with alt low.
- R6: With mode low, channel 2 shifts on falling ck_shf and latches on falling ck_lat. Its output 20+k gives codes 1, 2, 5, 6 for the four combinations in the same order as R5.
- R7: With mode high, channel 2 shifts on rising ck_lat and latches on rising ck_shf. Falling edges do nothing to channel 2, and channel 1 keeps the behaviour of R2 to R4.
- R8: With mode high, channel 2 gives codes 2, 1, 6, 5 for the four combinations in the order of R5.
- R9: When a shift edge and a latch edge of the same channel fall in the same cycle, the latch takes the register contents from before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ck_lat | input | 1 | Latch strobe (shift strobe of channel 2 when mode is high) |
| ck_shf | input | 1 | Shift strobe (latch strobe of channel 2 when mode is high) |
| mode | input | 1 | High selects row-driver behaviour for channel 2 |
| alt | input | 1 | Drive-waveform alternation signal |
| dir1 | input | 1 | Channel 1 direction: high takes data from the right pin |
| dir2 | input | 1 | Channel 2 direction: high takes data from the right pin |
| c1_left | inout | 1 | Channel 1 left data pin |
| c1_right | inout | 1 | Channel 1 right data pin |
| c2_left | inout | 1 | Channel 2 left data pin |
| c2_right | inout | 1 | Channel 2 right data pin |
| rail | output | 120 | Forty 3-bit rail codes, output n at bits 3n+2..3n |

## Verification
A shift and a latch can land in the same sampling cycle. The bench provokes this by lowering both strobes in one step with mode low, right after loading a known pattern. It judges the result by checking that the rail codes show the pattern from before the shift. A later lone latch pulse must then show the pattern moved by one position, with the new bit at position 19. With mode high, one strobe can shift channel 2 while its falling edge latches channel 1. Channel 1's codes must stay unchanged through that sequence.

// File: rtl/lcd_dual_drv.sv
module lcd_dual_drv #(
  parameter int W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ck_lat,
  input  logic             ck_shf,
  input  logic             mode,
  input  logic             alt,
  input  logic             dir1,
  input  logic             dir2,
  inout  wire              c1_left,
  inout  wire              c1_right,
  inout  wire              c2_left,
  inout  wire              c2_right,
  output logic [6*W-1:0]   rail
);

  logic [1:0] s_lat, s_shf, s_d1, s_d2;
  logic       p_lat, p_shf;
  logic [W-1:0] sr1, sr2, lat1, lat2;
  logic       in1, in2;
  logic       lat_fall, lat_rise, shf_fall, shf_rise;
  logic       sh1, ld1, sh2, ld2;

  assign in1 = dir1 ? c1_right : c1_left;
  assign in2 = dir2 ? c2_right : c2_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_lat <= 2'b11;
      s_shf <= 2'b11;
      p_lat <= 1'b1;
      p_shf <= 1'b1;
      s_d1  <= 2'b00;
      s_d2  <= 2'b00;
    end else begin
      s_lat <= {s_lat[0], ck_lat};
      s_shf <= {s_shf[0], ck_shf};
      p_lat <= s_lat[1];
      p_shf <= s_shf[1];
      s_d1  <= {s_d1[0], in1};
      s_d2  <= {s_d2[0], in2};
    end
  end

  assign lat_fall = p_lat & ~s_lat[1];
  assign lat_rise = ~p_lat & s_lat[1];
  assign shf_fall = p_shf & ~s_shf[1];
  assign shf_rise = ~p_shf & s_shf[1];

  assign sh1 = shf_fall;
  assign ld1 = lat_fall;
  assign sh2 = mode ? lat_rise : shf_fall;
  assign ld2 = mode ? shf_rise : lat_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr1  <= '0;
      sr2  <= '0;
      lat1 <= '0;
      lat2 <= '0;
    end else begin
      if (sh1) sr1 <= dir1 ? {s_d1[1], sr1[W-1:1]} : {sr1[W-2:0], s_d1[1]};
      if (sh2) sr2 <= dir2 ? {s_d2[1], sr2[W-1:1]} : {sr2[W-2:0], s_d2[1]};
      if (ld1) lat1 <= sr1;
      if (ld2) lat2 <= sr2;
    end
  end

  assign c1_left  = dir1 ? sr1[0]   : 1'bz;
  assign c1_right = dir1 ? 1'bz     : sr1[W-1];
  assign c2_left  = dir2 ? sr2[0]   : 1'bz;
  assign c2_right = dir2 ? 1'bz     : sr2[W-1];

  for (genvar k = 0; k < W; k++) begin : g_out
    logic [2:0] base2;
    assign rail[3*k +: 3] = lat1[k] ? (alt ? 3'd1 : 3'd2) : (alt ? 3'd3 : 3'd4);
    assign base2 = lat2[k] ? (alt ? 3'd1 : 3'd2) : (alt ? 3'd5 : 3'd6);
    assign rail[3*(W+k) +: 3] = base2 ^ {1'b0, mode, mode};
  end

endmodule

module lcd_dual_drv_chk #(
  parameter int W = 20
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sh1,
  input logic           ld1,
  input logic           ld2,
  input logic [W-1:0]   sr1,
  input logic [W-1:0]   sr2,
  input logic [W-1:0]   lat1,
  input logic [W-1:0]   lat2,
  input logic [6*W-1:0] rail
);

  // R2
  sr1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sh1 |=> $stable(sr1));

  // R4
  lat1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld1 |=> $stable(lat1));

  // R9
  lat1_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld1 |=> lat1 == $past(sr1));

  // R7
  lat2_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld2 |=> lat2 == $past(sr2));

  for (genvar k = 0; k < W; k++) begin : g_code
    // R5
    c1_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rail[3*k +: 3] >= 3'd1 && rail[3*k +: 3] <= 3'd4);
    // R8
    c2_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rail[3*(W+k) +: 3] inside {3'd1, 3'd2, 3'd5, 3'd6});
  end

endmodule

bind lcd_dual_drv lcd_dual_drv_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sh1(sh1), .ld1(ld1), .ld2(ld2),
  .sr1(sr1), .sr2(sr2), .lat1(lat1), .lat2(lat2), .rail(rail)
);

// File: tb/lcd_dual_drv_test.sv
`timescale 1ns/1ps
module lcd_dual_drv_test;
  localparam int W = 20;

  logic clk = 0, rst_n = 0, ck_lat = 1, ck_shf = 1, mode = 0, alt = 1;
  logic dir1 = 1, dir2 = 0;
  logic b1l = 0, b1r = 0, b2l = 0, b2r = 0;
  wire  c1_left, c1_right, c2_left, c2_right;
  logic [6*W-1:0] rail;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  assign c1_left  = dir1 ? 1'bz : b1l;
  assign c1_right = dir1 ? b1r  : 1'bz;
  assign c2_left  = dir2 ? 1'bz : b2l;
  assign c2_right = dir2 ? b2r  : 1'bz;

  lcd_dual_drv #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .ck_lat(ck_lat), .ck_shf(ck_shf), .mode(mode), .alt(alt),
    .dir1(dir1), .dir2(dir2), .c1_left(c1_left), .c1_right(c1_right),
    .c2_left(c2_left), .c2_right(c2_right), .rail(rail));

  // mode, alt, c1 hi, c1 lo, c2 hi, c2 lo
  localparam logic [13:0] VEC [4] = '{
    {1'b0, 1'b1, 3'd1, 3'd3, 3'd1, 3'd5},
    {1'b0, 1'b0, 3'd2, 3'd4, 3'd2, 3'd6},
    {1'b1, 1'b1, 3'd1, 3'd3, 3'd2, 3'd6},
    {1'b1, 1'b0, 3'd2, 3'd4, 3'd1, 3'd5}
  };

  function automatic logic [3*W-1:0] exp1(logic [W-1:0] b, logic a);
    logic [3*W-1:0] r;
    for (int k = 0; k < W; k++)
      r[3*k +: 3] = b[k] ? (a ? 3'd1 : 3'd2) : (a ? 3'd3 : 3'd4);
    return r;
  endfunction

  function automatic logic [3*W-1:0] exp2(logic [W-1:0] b, logic a, logic m);
    logic [3*W-1:0] r;
    logic [2:0] c;
    for (int k = 0; k < W; k++) begin
      if (!m) c = b[k] ? (a ? 3'd1 : 3'd2) : (a ? 3'd5 : 3'd6);
      else    c = b[k] ? (a ? 3'd2 : 3'd1) : (a ? 3'd6 : 3'd5);
      r[3*k +: 3] = c;
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [3*W-1:0] act, logic [3*W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load0(logic [W-1:0] p1, logic [W-1:0] p2);
    for (int i = 0; i < W; i++) begin
      if (dir1) b1r = p1[i]; else b1l = p1[W-1-i];
      if (dir2) b2r = p2[i]; else b2l = p2[W-1-i];
      tick(1);
      ck_shf = 0; tick(5);
      ck_shf = 1; tick(5);
    end
  endtask

  task automatic pulse_lat;
    ck_lat = 0; tick(5);
    ck_lat = 1; tick(5);
  endtask

  localparam logic [W-1:0] P1 = 20'hA5C3E, P2 = 20'h3B71D, Q2 = 20'hC0F35;
  localparam logic [W-1:0] S1 = 20'h69A17, S2 = 20'h1E2D4;

  initial begin
    tick(3);
    // R1: reset state
    chk("R1 ch1", rail[3*W-1:0], exp1('0, 1'b1));
    chk("R1 ch2", rail[6*W-1:3*W], exp2('0, 1'b1, 1'b0));
    chk_bit("R1 c1_left", c1_left, 1'b0);
    chk_bit("R1 c2_right", c2_right, 1'b0);
    rst_n = 1; tick(3);

    // R2 / R3: ch1 from the right, ch2 from the left
    load0(P1, P2);
    chk_bit("R2 c1_left end bit", c1_left, P1[0]);
    chk_bit("R3 c2_right end bit", c2_right, P2[W-1]);
    chk("R4 ch1 unchanged before latch", rail[3*W-1:0], exp1('0, 1'b1));
    chk("R4 ch2 unchanged before latch", rail[6*W-1:3*W], exp2('0, 1'b1, 1'b0));
    pulse_lat;
    chk("R4 ch1 latched", rail[3*W-1:0], exp1(P1, 1'b1));
    chk("R6 ch2 latched", rail[6*W-1:3*W], exp2(P2, 1'b1, 1'b0));

    // R5 / R6 / R8: table walk over mode and alt
    for (int v = 0; v < 4; v++) begin
      mode = VEC[v][13]; alt = VEC[v][12];
      tick(2);
      for (int k = 0; k < W; k++) begin
        chk(mode ? "R5 ch1 (mode high)" : "R5 ch1", {57'd0, rail[3*k +: 3]},
            {57'd0, P1[k] ? VEC[v][11:9] : VEC[v][8:6]});
        chk(mode ? "R8 ch2" : "R6 ch2", {57'd0, rail[3*(W+k) +: 3]},
            {57'd0, P2[k] ? VEC[v][5:3] : VEC[v][2:0]});
      end
    end

    // R7: mode high, ch2 shifts on rising ck_lat, latches on rising ck_shf
    mode = 1; alt = 0; dir2 = 1; tick(2);
    for (int i = 0; i < W; i++) begin
      b2r = Q2[i]; tick(1);
      ck_lat = 0; tick(5);
      ck_lat = 1; tick(5);
    end
    chk_bit("R7 c2_left end bit", c2_left, Q2[0]);
    chk("R7 ch2 not latched yet", rail[6*W-1:3*W], exp2(P2, 1'b0, 1'b1));
    chk("R7 ch1 kept", rail[3*W-1:0], exp1(P1, 1'b0));
    b1r = 0;
    ck_shf = 0; tick(5);
    chk("R7 falling ck_shf ignored by ch2", rail[6*W-1:3*W], exp2(P2, 1'b0, 1'b1));
    ck_shf = 1; tick(5);
    chk("R7 ch2 latched on rising ck_shf", rail[6*W-1:3*W], exp2(Q2, 1'b0, 1'b1));
    chk("R4 ch1 not latched by ck_shf", rail[3*W-1:0], exp1(P1, 1'b0));

    // R9: shift and latch in the same cycle
    mode = 0; alt = 1; dir1 = 1; dir2 = 1; tick(2);
    load0(S1, S2);
    b1r = 1; b2r = 0; tick(1);
    ck_shf = 0; ck_lat = 0; tick(5);
    chk("R9 ch1 pre-shift contents", rail[3*W-1:0], exp1(S1, 1'b1));
    chk("R9 ch2 pre-shift contents", rail[6*W-1:3*W], exp2(S2, 1'b1, 1'b0));
    ck_shf = 1; ck_lat = 1; tick(5);
    pulse_lat;
    chk("R9 ch1 after lone latch", rail[3*W-1:0], exp1({1'b1, S1[W-1:1]}, 1'b1));
    chk("R9 ch2 after lone latch", rail[6*W-1:3*W], exp2({1'b0, S2[W-1:1]}, 1'b1, 1'b0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule